// File: doc/BRIEF.md
# Match and Capture Timer

A 32-bit timer/counter for general timing work inside a larger chip. A prescale counter divides the count events. Each event is either a bus clock cycle or an edge on one of the capture inputs, picked by a select field. The timer counter advances once per (prescale + 1) events. Four match channels compare the timer counter with their own compare values. On a hit, each channel can reload the counter to zero, halt it, latch an interrupt flag, and change its own external output pin through a 2-bit action code.

Four capture channels watch asynchronous input pins. Each pin passes through a two-flop synchronizer and then an edge detector. On the edge chosen for that channel, the current counter value is copied into the channel's capture register and a flag is latched. The flags sit in one status word, and writing a mask to that word clears the flags whose bits are set. The interrupt line is the OR of every flag whose enable bit is set. Software reaches all of this through a word-addressed write port and a read port with one cycle of read latency (`bus_rdata` holds the word addressed on the previous clock).

Register map (word addresses):
- 0 control: [0] run, [1] clear.
- 1 mode: [1:0] count source, [3:2] counting input select.
- 2 prescale value.
- 3 timer count, read only.
- 4 prescale count, read only.
- 5 match control.
- 6 capture control.
- 7 output control.
- 8 flags.
- 16+i compare value of match channel i.
- 24+i capture value of capture channel i.

Top module: `mcap_timer`

## Requirements
- R1: After reset, every register reads zero: count source 0 (bus clock), input select 0, prescale 0, count 0. `match_out` and `irq` are low.
- R2: With count source 0 and prescale P, the counter advances once every P+1 cycles while running. If match channel 0 (control bit 1) reloads at compare value M and its output toggles, `match_out[0]` toggles every (M+1)*(P+1) cycles.
- R3: Count source codes 1, 2 and 3 count the rising edges, the falling edges, or both edges of the capture input chosen by mode bits [3:2]. Other inputs are ignored. Edges also pass through the prescaler.
- R4: A match on a channel with its halt bit set (match control bit 3i+2) leaves the counter at the compare value and clears the run bit.
- R5: When a reload (bit 3i+1) and a halt meet in the same cycle, the counter becomes zero and the run bit is cleared. A reload always takes the place of the increment.
- R6: Writing control bit 1 as 1 zeroes the timer count and the prescale count at that clock edge. Both stay zero while the bit is held.
- R7: Output control bits [3:0] load the output levels. Bits [4+2i+1:4+2i] give channel i's action on a match: 0 keep, 1 drive low, 2 drive high, 3 invert.
- R8: Capture control bits [3i+1:3i] select the edge for channel i: 0 off, 1 rising, 2 falling, 3 both. On that edge the count is latched into capture register i and flag bit 4+i is set. The other edge has no effect.
- R9: Match channel i sets flag bit i on each match. A write to the flags word clears the flags whose mask bits are 1. An event that coincides with its own clear leaves the flag set.
- R10: `irq` equals the OR of flags[i] AND enable[i], in the same cycle as the flags. The enables are match control bit 3i (match i) and capture control bit 3i+2 (capture i).
- R11: While the run bit (control bit 0) is zero, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_in | input | 4 | Asynchronous capture / count inputs |
| match_out | output | 4 | External match output levels |
| irq | output | 1 | Interrupt request |

## Verification
A capture edge can set its flag in the same clock edge that a software write to the flags word clears it. The bench times the flags write to land exactly two cycles after the input rises, which is the cycle the synchronized edge is acted upon. It then expects the captured flag alone to survive while every other flag is cleared. A second collision, reload and halt matching together, is judged by reading a count of zero with the run bit cleared.

// File: rtl/mcap_pkg.sv
package mcap_pkg;

  localparam int A_CTRL       = 0;
  localparam int A_MODE       = 1;
  localparam int A_PRESCALE   = 2;
  localparam int A_COUNT      = 3;
  localparam int A_PRECOUNT   = 4;
  localparam int A_MATCH_CTRL = 5;
  localparam int A_CAP_CTRL   = 6;
  localparam int A_OUT_CTRL   = 7;
  localparam int A_FLAGS      = 8;
  localparam int A_MATCH_BASE = 16;
  localparam int A_CAP_BASE   = 24;

  typedef enum logic [1:0] {
    CM_BUS  = 2'd0,
    CM_RISE = 2'd1,
    CM_FALL = 2'd2,
    CM_BOTH = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    OA_KEEP = 2'd0,
    OA_LOW  = 2'd1,
    OA_HIGH = 2'd2,
    OA_FLIP = 2'd3
  } out_act_e;

  function automatic logic next_level(input logic cur, input logic [1:0] act);
    case (out_act_e'(act))
      OA_LOW:  return 1'b0;
      OA_HIGH: return 1'b1;
      OA_FLIP: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/mcap_sync_edge.sv
module mcap_sync_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;
endmodule

// File: rtl/mcap_count_core.sv
module mcap_count_core
  import mcap_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4,
  parameter int SEL_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           run,
  input  logic                           clr,
  input  logic [1:0]                     mode,
  input  logic [SEL_W-1:0]               sel,
  input  logic [N_CAP-1:0]               rise,
  input  logic [N_CAP-1:0]               fall,
  input  logic [CNT_W-1:0]               prescale,
  input  logic [N_MATCH-1:0][CNT_W-1:0]  match_val,
  input  logic [N_MATCH-1:0]             rst_en,
  input  logic [N_MATCH-1:0]             stop_en,
  output logic [CNT_W-1:0]               tc,
  output logic [CNT_W-1:0]               pc,
  output logic [N_MATCH-1:0]             hit,
  output logic                           rst_req,
  output logic                           stop_req
);
  logic ev, active, tick;

  // Count event source selection
  always_comb begin
    case (cnt_mode_e'(mode))
      CM_BUS:  ev = 1'b1;
      CM_RISE: ev = rise[sel];
      CM_FALL: ev = fall[sel];
      default: ev = rise[sel] | fall[sel];
    endcase
  end

  assign active = run & ~clr & ev;
  assign tick   = active & (pc >= prescale);

  // Compare happens only on the tick that would advance the counter
  for (genvar i = 0; i < N_MATCH; i++) begin : g_cmp
    assign hit[i] = tick & (tc == match_val[i]);
  end

  assign rst_req  = |(hit & rst_en);
  assign stop_req = |(hit & stop_en);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tc <= '0;
      pc <= '0;
    end else if (active) begin
      if (tick) begin
        pc <= '0;
        if (rst_req)       tc <= '0;
        else if (!stop_req) tc <= tc + CNT_W'(1);
      end else begin
        pc <= pc + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mcap_capture_bank.sv
module mcap_capture_bank #(
  parameter int CNT_W = 32,
  parameter int N_CAP = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_CAP-1:0]             rise,
  input  logic [N_CAP-1:0]             fall,
  input  logic [N_CAP-1:0][1:0]        edge_sel,
  input  logic [CNT_W-1:0]             tc,
  output logic [N_CAP-1:0][CNT_W-1:0]  cap_val,
  output logic [N_CAP-1:0]             cap_hit
);
  for (genvar i = 0; i < N_CAP; i++) begin : g_ch
    logic [CNT_W-1:0] val_q;

    assign cap_hit[i] = (edge_sel[i][0] & rise[i]) | (edge_sel[i][1] & fall[i]);

    always_ff @(posedge clk) begin
      if (rst)             val_q <= '0;
      else if (cap_hit[i]) val_q <= tc;
    end

    assign cap_val[i] = val_q;
  end
endmodule

// File: rtl/mcap_match_out.sv
module mcap_match_out
  import mcap_pkg::*;
#(
  parameter int N_MATCH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [N_MATCH-1:0]        load_lvl,
  input  logic [N_MATCH-1:0][1:0]   act,
  input  logic [N_MATCH-1:0]        hit,
  output logic [N_MATCH-1:0]        lvl
);
  for (genvar i = 0; i < N_MATCH; i++) begin : g_out
    logic lvl_q, base;

    // A level write in the same cycle as a match is the value the action works on
    assign base = load ? load_lvl[i] : lvl_q;

    always_ff @(posedge clk) begin
      if (rst)         lvl_q <= 1'b0;
      else if (hit[i]) lvl_q <= next_level(base, act[i]);
      else             lvl_q <= base;
    end

    assign lvl[i] = lvl_q;
  end
endmodule

// File: rtl/mcap_timer.sv
module mcap_timer
  import mcap_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4,
  parameter int ADDR_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CNT_W-1:0]    bus_wdata,
  output logic [CNT_W-1:0]    bus_rdata,
  input  logic [N_CAP-1:0]    cap_in,
  output logic [N_MATCH-1:0]  match_out,
  output logic                irq
);
  localparam int SEL_W    = (N_CAP > 1) ? $clog2(N_CAP) : 1;
  localparam int NF       = N_MATCH + N_CAP;
  localparam int OACT_LSB = N_MATCH;

  // Write decode
  logic wr_ctrl, wr_mode, wr_pre, wr_mctrl, wr_cctrl, wr_oct, wr_flags;
  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_mode  = bus_we && (bus_addr == ADDR_W'(A_MODE));
  assign wr_pre   = bus_we && (bus_addr == ADDR_W'(A_PRESCALE));
  assign wr_mctrl = bus_we && (bus_addr == ADDR_W'(A_MATCH_CTRL));
  assign wr_cctrl = bus_we && (bus_addr == ADDR_W'(A_CAP_CTRL));
  assign wr_oct   = bus_we && (bus_addr == ADDR_W'(A_OUT_CTRL));
  assign wr_flags = bus_we && (bus_addr == ADDR_W'(A_FLAGS));

  // Configuration state
  logic                          run_q, clr_q;
  logic [1:0]                    mode_q;
  logic [SEL_W-1:0]              sel_q;
  logic [CNT_W-1:0]              pre_q;
  logic [N_MATCH-1:0][CNT_W-1:0] mval_q;
  logic [N_MATCH-1:0]            m_irq_q, m_rst_q, m_stop_q;
  logic [N_MATCH-1:0][1:0]       m_act_q;
  logic [N_CAP-1:0][1:0]         c_edge_q;
  logic [N_CAP-1:0]              c_irq_q;
  logic [NF-1:0]                 flags_q;
  logic                          irq_q;
  logic [CNT_W-1:0]              rdata_q;

  // Datapath nets
  logic [CNT_W-1:0]              tc, pc;
  logic [N_MATCH-1:0]            hit;
  logic                          rst_req, stop_req, clr_cmd;
  logic [N_CAP-1:0]              rise, fall, cap_hit;
  logic [N_CAP-1:0][CNT_W-1:0]   cap_val;
  logic [N_MATCH-1:0]            lvl;

  // Clear acts on the edge that writes it and for as long as it is held
  assign clr_cmd = clr_q | (wr_ctrl & bus_wdata[1]);

  mcap_sync_edge #(.N(N_CAP)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cap_in),
    .rise (rise),
    .fall (fall)
  );

  mcap_count_core #(
    .CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_CAP(N_CAP), .SEL_W(SEL_W)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .run       (run_q),
    .clr       (clr_cmd),
    .mode      (mode_q),
    .sel       (sel_q),
    .rise      (rise),
    .fall      (fall),
    .prescale  (pre_q),
    .match_val (mval_q),
    .rst_en    (m_rst_q),
    .stop_en   (m_stop_q),
    .tc        (tc),
    .pc        (pc),
    .hit       (hit),
    .rst_req   (rst_req),
    .stop_req  (stop_req)
  );

  mcap_capture_bank #(.CNT_W(CNT_W), .N_CAP(N_CAP)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .fall     (fall),
    .edge_sel (c_edge_q),
    .tc       (tc),
    .cap_val  (cap_val),
    .cap_hit  (cap_hit)
  );

  mcap_match_out #(.N_MATCH(N_MATCH)) u_mout (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_oct),
    .load_lvl (bus_wdata[N_MATCH-1:0]),
    .act      (m_act_q),
    .hit      (hit),
    .lvl      (lvl)
  );

  // Next enables and flags, so that irq is registered in step with the flags
  logic [N_MATCH-1:0] m_irq_d;
  logic [N_CAP-1:0]   c_irq_d;
  logic [NF-1:0]      irq_en_d, irq_en_q, clr_mask, flags_d;

  always_comb begin
    m_irq_d = m_irq_q;
    c_irq_d = c_irq_q;
    if (wr_mctrl)
      for (int i = 0; i < N_MATCH; i++) m_irq_d[i] = bus_wdata[3*i];
    if (wr_cctrl)
      for (int i = 0; i < N_CAP; i++) c_irq_d[i] = bus_wdata[3*i+2];
  end

  assign irq_en_d = {c_irq_d, m_irq_d};
  assign irq_en_q = {c_irq_q, m_irq_q};
  assign clr_mask = wr_flags ? bus_wdata[NF-1:0] : '0;
  assign flags_d  = (flags_q & ~clr_mask) | {cap_hit, hit};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      clr_q    <= 1'b0;
      mode_q   <= 2'd0;
      sel_q    <= '0;
      pre_q    <= '0;
      mval_q   <= '0;
      m_irq_q  <= '0;
      m_rst_q  <= '0;
      m_stop_q <= '0;
      m_act_q  <= '0;
      c_edge_q <= '0;
      c_irq_q  <= '0;
      flags_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (stop_req)     run_q <= 1'b0;
      else if (wr_ctrl) run_q <= bus_wdata[0];
      if (wr_ctrl) clr_q <= bus_wdata[1];
      if (wr_mode) begin
        mode_q <= bus_wdata[1:0];
        sel_q  <= bus_wdata[2 +: SEL_W];
      end
      if (wr_pre) pre_q <= bus_wdata;
      for (int i = 0; i < N_MATCH; i++)
        if (bus_we && (bus_addr == ADDR_W'(A_MATCH_BASE + i))) mval_q[i] <= bus_wdata;
      if (wr_mctrl)
        for (int i = 0; i < N_MATCH; i++) begin
          m_rst_q[i]  <= bus_wdata[3*i+1];
          m_stop_q[i] <= bus_wdata[3*i+2];
        end
      if (wr_cctrl)
        for (int i = 0; i < N_CAP; i++) c_edge_q[i] <= bus_wdata[3*i +: 2];
      if (wr_oct)
        for (int i = 0; i < N_MATCH; i++) m_act_q[i] <= bus_wdata[OACT_LSB + 2*i +: 2];
      m_irq_q <= m_irq_d;
      c_irq_q <= c_irq_d;
      flags_q <= flags_d;
      irq_q   <= |(flags_d & irq_en_d);
    end
  end

  // Read path
  logic [CNT_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL):     rd_mux[1:0] = {clr_q, run_q};
      ADDR_W'(A_MODE): begin
        rd_mux[1:0]        = mode_q;
        rd_mux[2 +: SEL_W] = sel_q;
      end
      ADDR_W'(A_PRESCALE): rd_mux = pre_q;
      ADDR_W'(A_COUNT):    rd_mux = tc;
      ADDR_W'(A_PRECOUNT): rd_mux = pc;
      ADDR_W'(A_MATCH_CTRL):
        for (int i = 0; i < N_MATCH; i++)
          rd_mux[3*i +: 3] = {m_stop_q[i], m_rst_q[i], m_irq_q[i]};
      ADDR_W'(A_CAP_CTRL):
        for (int i = 0; i < N_CAP; i++)
          rd_mux[3*i +: 3] = {c_irq_q[i], c_edge_q[i]};
      ADDR_W'(A_OUT_CTRL): begin
        rd_mux[N_MATCH-1:0] = lvl;
        for (int i = 0; i < N_MATCH; i++) rd_mux[OACT_LSB + 2*i +: 2] = m_act_q[i];
      end
      ADDR_W'(A_FLAGS):    rd_mux[NF-1:0] = flags_q;
      default: ;
    endcase
    for (int i = 0; i < N_MATCH; i++)
      if (bus_addr == ADDR_W'(A_MATCH_BASE + i)) rd_mux = mval_q[i];
    for (int i = 0; i < N_CAP; i++)
      if (bus_addr == ADDR_W'(A_CAP_BASE + i)) rd_mux = cap_val[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign match_out = lvl;
  assign irq       = irq_q;
endmodule

// File: rtl/mcap_timer_chk.sv
module mcap_timer_chk #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       run_q,
  input logic                       clr_cmd,
  input logic [CNT_W-1:0]           tc,
  input logic [CNT_W-1:0]           pc,
  input logic [N_MATCH-1:0]         hit,
  input logic [N_MATCH-1:0]         m_rst,
  input logic [N_MATCH-1:0]         m_stop,
  input logic [N_CAP-1:0]           cap_hit,
  input logic [N_MATCH+N_CAP-1:0]   flags,
  input logic [N_MATCH+N_CAP-1:0]   irq_en,
  input logic                       irq
);
  localparam int NF = N_MATCH + N_CAP;

  // R11: no run, no clear -> counter holds
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !clr_cmd) |=> $stable(tc));

  // R2: counter never moves by more than one step except on reload or clear
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (!clr_cmd && !(|(hit & m_rst))) |=> (tc == $past(tc) || tc == $past(tc) + CNT_W'(1)));

  // R5: reload wins over increment and halt
  a_r5_reload_wins: assert property (@(posedge clk) disable iff (rst)
    (|(hit & m_rst)) |=> (tc == '0));

  // R4: halt clears run and keeps the compare value
  a_r4_halt_clears_run: assert property (@(posedge clk) disable iff (rst)
    (|(hit & m_stop)) |=> !run_q);

  a_r4_halt_keeps_count: assert property (@(posedge clk) disable iff (rst)
    ((|(hit & m_stop)) && !(|(hit & m_rst))) |=> $stable(tc));

  // R6: clear zeroes both counters
  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (tc == '0 && pc == '0));

  // R9: an event always leaves its flag set, even against a clear
  a_r9_match_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((flags[N_MATCH-1:0] & $past(hit)) == $past(hit)));

  // R8: a capture sets its flag
  a_r8_capture_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (cap_hit != '0) |=> ((flags[NF-1:N_MATCH] & $past(cap_hit)) == $past(cap_hit)));

  // R10: interrupt line tracks the enabled flags cycle for cycle
  a_r10_irq_tracks_flags: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq == |(flags & irq_en)));
endmodule

bind mcap_timer mcap_timer_chk #(
  .CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_CAP(N_CAP)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run_q   (run_q),
  .clr_cmd (clr_cmd),
  .tc      (tc),
  .pc      (pc),
  .hit     (hit),
  .m_rst   (m_rst_q),
  .m_stop  (m_stop_q),
  .cap_hit (cap_hit),
  .flags   (flags_q),
  .irq_en  (irq_en_q),
  .irq     (irq_q)
);

// File: tb/sim_mcap_timer.sv
`timescale 1ns/1ps
module sim_mcap_timer;
  localparam int A_CTRL = 0, A_MODE = 1, A_PRE = 2, A_CNT = 3, A_PCNT = 4;
  localparam int A_MCTL = 5, A_CCTL = 6, A_OCTL = 7, A_FLG = 8, A_MV = 16, A_CV = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap = '0;
  logic [3:0]  mout;
  logic        irq;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  mcap_timer u0 (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .cap_in(cap), .match_out(mout), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    addr = 5'(a);
    @(posedge clk);
    #1 v = rdata;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); cap[ch] = 1'b1;
    repeat (3) @(negedge clk);
    cap[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_toggle(output int at);
    logic prev;
    prev = mout[0];
    at = -1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (mout[0] !== prev) begin
        at = cyc;
        break;
      end
    end
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int t1, t2;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_MODE, v);  chk("R1 mode", v, 0);
    rd(A_PRE, v);   chk("R1 prescale", v, 0);
    rd(A_CNT, v);   chk("R1 count", v, 0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_FLG, v);   chk("R1 flags", v, 0);
    chk("R1 match_out", {28'd0, mout}, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 period sweep: prescale x compare value
    for (int p = 0; p < 4; p++) begin
      for (int m = 1; m < 5; m++) begin
        wr(A_CTRL, 2);
        wr(A_PRE, p);
        wr(A_MV + 0, m);
        wr(A_MCTL, 32'h2);
        wr(A_OCTL, 32'h3 << 4);
        wr(A_CTRL, 1);
        wait_toggle(t1);
        wait_toggle(t2);
        chk($sformatf("R2 period p=%0d m=%0d", p, m), t2 - t1, (m + 1) * (p + 1));
      end
    end

    // R3 edge counting sweep: source code x selected input
    wr(A_MCTL, 0);
    wr(A_OCTL, 0);
    for (int md = 1; md < 4; md++) begin
      for (int s = 0; s < 4; s++) begin
        wr(A_CTRL, 2);
        wr(A_PRE, 0);
        wr(A_MODE, md | (s << 2));
        wr(A_CTRL, 1);
        for (int k = 0; k < 5; k++) begin
          pulse(s);
          if (k < 2) pulse((s + 1) % 4);
        end
        repeat (4) @(negedge clk);
        rd(A_CNT, v);
        chk($sformatf("R3 edge count mode=%0d sel=%0d", md, s), v, (md == 3) ? 10 : 5);
      end
    end

    // R3 prescaled edge counting
    wr(A_CTRL, 2);
    wr(A_PRE, 2);
    wr(A_MODE, 1);
    wr(A_CTRL, 1);
    for (int k = 0; k < 10; k++) pulse(0);
    repeat (4) @(negedge clk);
    rd(A_CNT, v);  chk("R3 prescaled count", v, 3);
    rd(A_PCNT, v); chk("R3 prescale remainder", v, 1);

    // R11 hold while not running
    wr(A_CTRL, 2);
    wr(A_MODE, 0);
    wr(A_PRE, 0);
    wr(A_CTRL, 1);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 0);
    rd(A_CNT, v);
    repeat (10) @(negedge clk);
    rd(A_CNT, v2);
    chk("R11 count held", v2, v);
    chk("R11 count advanced before stop", {31'd0, (v > 0)}, 1);

    // R6 clear zeroes both counters
    wr(A_PRE, 5);
    wr(A_CTRL, 1);
    repeat (23) @(negedge clk);
    wr(A_CTRL, 3);
    repeat (3) @(negedge clk);
    rd(A_CNT, v);  chk("R6 count cleared", v, 0);
    rd(A_PCNT, v); chk("R6 prescale count cleared", v, 0);

    // R4 halt on match
    wr(A_CTRL, 2);
    wr(A_PRE, 0);
    wr(A_MV + 0, 5);
    wr(A_MCTL, 32'h4);
    wr(A_CTRL, 1);
    repeat (20) @(negedge clk);
    rd(A_CNT, v);  chk("R4 halted at compare", v, 5);
    rd(A_CTRL, v); chk("R4 run cleared", v, 0);

    // R5 reload and halt in the same cycle
    wr(A_CTRL, 2);
    wr(A_MV + 1, 7);
    wr(A_MV + 2, 7);
    wr(A_MCTL, (1 << 4) | (1 << 8));
    wr(A_CTRL, 1);
    repeat (20) @(negedge clk);
    rd(A_CNT, v);  chk("R5 reload wins", v, 0);
    rd(A_CTRL, v); chk("R5 run cleared", v, 0);

    // R7 output actions
    wr(A_CTRL, 2);
    for (int i = 0; i < 4; i++) wr(A_MV + i, 2);
    wr(A_MCTL, 32'h4);
    wr(A_OCTL, 32'hA | (2 << 4) | (1 << 6) | (3 << 8));
    chk("R7 initial levels", {28'd0, mout}, 32'hA);
    wr(A_FLG, 32'hFF);
    wr(A_CTRL, 1);
    repeat (10) @(negedge clk);
    chk("R7 levels after match", {28'd0, mout}, 32'hD);
    rd(A_OCTL, v); chk("R7 level readback", v & 32'hF, 32'hD);

    // R9 / R10 flags and interrupt masking
    rd(A_FLG, v);  chk("R9 match flags", v, 32'h0F);
    chk("R10 irq masked", {31'd0, irq}, 0);
    wr(A_MCTL, 32'h5);
    chk("R10 irq enabled", {31'd0, irq}, 1);
    wr(A_FLG, 32'h1);
    rd(A_FLG, v);  chk("R9 masked clear", v, 32'h0E);
    chk("R10 irq after clear", {31'd0, irq}, 0);

    // R8 capture on selected edge
    wr(A_CCTL, (2 << 3) | (1 << 6));
    wr(A_FLG, 32'hFF);
    pulse(2);
    repeat (3) @(negedge clk);
    rd(A_CV + 2, v); chk("R8 rising capture value", v, 2);
    rd(A_FLG, v);    chk("R8 rising capture flag", v, 32'h40);
    @(negedge clk); cap[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_FLG, v);    chk("R8 rising edge ignored on falling channel", v, 32'h40);
    rd(A_CV + 1, v); chk("R8 no capture yet", v, 0);
    @(negedge clk); cap[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_FLG, v);    chk("R8 falling capture flag", v, 32'h60);
    rd(A_CV + 1, v); chk("R8 falling capture value", v, 2);

    // R9 capture set coinciding with a clear of all flags
    @(negedge clk); cap[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = 5'(A_FLG); wdata = 32'hFF;
    @(negedge clk);
    we = 1'b0;
    rd(A_FLG, v);  chk("R9 set wins over clear", v, 32'h40);
    @(negedge clk); cap[2] = 1'b0;
    repeat (4) @(negedge clk);

    // R10 capture interrupt enable
    wr(A_CCTL, (1 << 6) | (1 << 8));
    chk("R10 capture irq", {31'd0, irq}, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule